// File: doc/BRIEF.md
# Residue-to-Binary Converter (CRT)

This block turns a residue vector over the fixed, pairwise-coprime moduli 7, 11, 13 and 15 back into a signed binary integer using the Chinese Remainder Theorem. The product of the moduli, M = 15015, is the dynamic range. Each residue is mapped to a weighted term modulo M. A pipelined binary tree of modulo-M adders sums the terms into the reconstructed value X, with 0 <= X < M. A final stage folds the upper half of the range onto negative numbers.

A format select travels with each vector. It picks sign-magnitude or two's-complement coding for that vector's result. The pipeline takes one vector per clock with no stalls. A valid flag runs alongside the data.

Top module: `crt_decoder`

## Requirements
- R1: `res_i` packs four 4-bit residues. Bits [3:0] hold the residue mod 7, bits [7:4] mod 11, bits [11:8] mod 13 and bits [15:12] mod 15. Each residue must be below its modulus. The block decodes the unique X in [0, 15015) whose residues match.
- R2: When X < 7508 the signed result is X. When X >= 7508 the signed result is X - 15015. This gives a range of -7507 to +7507.
- R3: With `fmt_i` = 0, `data_o[14]` is the sign (1 = negative) and `data_o[13:0]` is the magnitude, 15015 - X for negative results. Zero is always coded as positive, and the magnitude never exceeds 7507.
- R4: With `fmt_i` = 1, `data_o` is the 15-bit two's-complement signed result, within -7507 to +7507.
- R5: `fmt_i` is captured with the residues of the same vector. Changing it on every cycle gives each result the format of its own vector.
- R6: A vector sampled with `valid_i` = 1 at a rising edge appears with `valid_o` = 1 after the fourth rising edge, counting the sampling edge as the first. One vector is accepted per cycle, back to back, with no loss.
- R7: While `valid_o` is 0, `data_o` keeps the last valid result.
- R8: After an asynchronous active-low reset, `valid_o` is 0 and `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input vector valid |
| fmt_i | input | 1 | Output coding: 0 sign-magnitude, 1 two's complement |
| res_i | input | 16 | Packed residues (lane order in R1) |
| valid_o | output | 1 | Result valid |
| data_o | output | 15 | Signed result in the selected coding |

## Verification
The hardest point to reach is the fold at the middle of the range. Values 7507 and 7508 decode to the largest positive and the most negative result. Their residue vectors look unrelated to each other, so only a full sweep hits both in both codings. The bench encodes every X from 0 to 15014 into residues itself and streams them back to back, once in each format. A third pass toggles the format on every cycle, so that a format captured against the wrong vector shows up as a mismatch.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int NMOD = 4;
    localparam int RW   = 4;
    localparam int MODS [NMOD] = '{7, 11, 13, 15};

    function automatic int prod_all();
        int p;
        p = 1;
        for (int i = 0; i < NMOD; i++) p = p * MODS[i];
        return p;
    endfunction

    function automatic int mod_inv(int a, int m);
        int r;
        r = 0;
        for (int k = 1; k < m; k++)
            if (r == 0 && ((a * k) % m) == 1) r = k;
        return r;
    endfunction

    localparam int MTOT = prod_all();
    localparam int SW   = $clog2(MTOT);
    localparam int OW   = SW + 1;
    localparam int HALF = (MTOT + 1) / 2;
    localparam int LVL  = $clog2(NMOD);
    localparam int LAT  = LVL + 2;
endpackage

// File: rtl/crt_term_gen.sv
module crt_term_gen #(
    parameter int RW     = 4,
    parameter int SW     = 14,
    parameter int MOD    = 7,
    parameter int WEIGHT = 2145,
    parameter int INV    = 5
) (
    input  logic [RW-1:0] res_i,
    output logic [SW-1:0] term_o
);
    int lane_v;

    always_comb begin
        lane_v = (int'(res_i) * INV) % MOD;
        term_o = SW'(lane_v * WEIGHT);
    end
endmodule

// File: rtl/crt_mod_add.sv
module crt_mod_add #(
    parameter int SW   = 14,
    parameter int MODV = 15015
) (
    input  logic [SW-1:0] a_i,
    input  logic [SW-1:0] b_i,
    output logic [SW-1:0] sum_o
);
    logic [SW+1:0] raw;
    logic [SW+1:0] diff;

    always_comb begin
        raw   = {2'b00, a_i} + {2'b00, b_i};
        diff  = raw - (SW+2)'(MODV);
        sum_o = diff[SW+1] ? raw[SW-1:0] : diff[SW-1:0];
    end
endmodule

// File: rtl/crt_range_fix.sv
module crt_range_fix #(
    parameter int SW    = 14,
    parameter int OW    = 15,
    parameter int MODV  = 15015,
    parameter int HALFV = 7508
) (
    input  logic [SW-1:0] x_i,
    input  logic          fmt_i,
    output logic [OW-1:0] data_o
);
    logic          neg;
    logic [SW-1:0] mag;
    logic [OW-1:0] tc;

    always_comb begin
        neg    = (x_i >= SW'(HALFV));
        mag    = neg ? (SW'(MODV) - x_i) : x_i;
        tc     = neg ? (OW'({1'b0, x_i}) - OW'(MODV)) : {1'b0, x_i};
        data_o = fmt_i ? tc : {neg, mag};
    end
endmodule

// File: rtl/crt_decoder.sv
module crt_decoder
    import crt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic                 fmt_i,
    input  logic [NMOD*RW-1:0]   res_i,
    output logic                 valid_o,
    output logic [OW-1:0]        data_o
);
    typedef struct packed {
        logic [LVL:0]                     vld;
        logic [LVL:0]                     fmt;
        logic [LVL:0][NMOD-1:0][SW-1:0]   sum;
        logic                             out_vld;
        logic [OW-1:0]                    out_data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [SW-1:0] term_w [NMOD];
    logic [SW-1:0] node_w [LVL][NMOD];
    logic [OW-1:0] fix_w;

    // Partial-sum generator: one weighted term per modulus
    for (genvar i = 0; i < NMOD; i++) begin : g_term
        crt_term_gen #(
            .RW    (RW),
            .SW    (SW),
            .MOD   (MODS[i]),
            .WEIGHT(MTOT / MODS[i]),
            .INV   (mod_inv((MTOT / MODS[i]) % MODS[i], MODS[i]))
        ) u_term (
            .res_i (res_i[i*RW +: RW]),
            .term_o(term_w[i])
        );
    end

    // Adder tree, one registered level per stage
    for (genvar l = 0; l < LVL; l++) begin : g_lvl
        for (genvar j = 0; j < NMOD; j++) begin : g_node
            if (j < (NMOD >> (l + 1))) begin : g_add
                crt_mod_add #(.SW(SW), .MODV(MTOT)) u_add (
                    .a_i  (pipe_q.sum[l][2*j]),
                    .b_i  (pipe_q.sum[l][2*j+1]),
                    .sum_o(node_w[l][j])
                );
            end else begin : g_zero
                assign node_w[l][j] = '0;
            end
        end
    end

    crt_range_fix #(.SW(SW), .OW(OW), .MODV(MTOT), .HALFV(HALF)) u_fix (
        .x_i   (pipe_q.sum[LVL][0]),
        .fmt_i (pipe_q.fmt[LVL]),
        .data_o(fix_w)
    );

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.vld[0] = valid_i;
        pipe_d.fmt[0] = fmt_i;
        for (int i = 0; i < NMOD; i++) pipe_d.sum[0][i] = term_w[i];
        for (int l = 0; l < LVL; l++) begin
            pipe_d.vld[l+1] = pipe_q.vld[l];
            pipe_d.fmt[l+1] = pipe_q.fmt[l];
            for (int j = 0; j < NMOD; j++) pipe_d.sum[l+1][j] = node_w[l][j];
        end
        pipe_d.out_vld = pipe_q.vld[LVL];
        if (pipe_q.vld[LVL]) pipe_d.out_data = fix_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign valid_o = pipe_q.out_vld;
    assign data_o  = pipe_q.out_data;
endmodule

// File: rtl/crt_decoder_chk.sv
module crt_decoder_chk #(
    parameter int OW   = 15,
    parameter int HALF = 7508,
    parameter int LAT  = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_i,
    input logic          fmt_i,
    input logic          valid_o,
    input logic [OW-1:0] data_o
);
    logic [3:0] warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  warm_q <= '0;
        else if (warm_q < 4'(LAT))   warm_q <= warm_q + 4'd1;
    end

    // R6
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 4'(LAT)) |-> (valid_o == $past(valid_i, 4)));

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));

    // R3
    sm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 4'(LAT) && valid_o && !$past(fmt_i, 4)) |->
        (data_o[OW-2:0] <= (OW-1)'(HALF - 1) &&
         !(data_o[OW-1] && data_o[OW-2:0] == '0)));

    // R4
    tc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 4'(LAT) && valid_o && $past(fmt_i, 4)) |->
        ($signed(data_o) <= $signed(OW'(HALF - 1)) &&
         $signed(data_o) >= -$signed(OW'(HALF - 1))));
endmodule

bind crt_decoder crt_decoder_chk #(
    .OW  (crt_pkg::OW),
    .HALF(crt_pkg::HALF),
    .LAT (crt_pkg::LAT)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid_i(valid_i),
    .fmt_i  (fmt_i),
    .valid_o(valid_o),
    .data_o (data_o)
);

// File: tb/sim_crt_decoder.sv
`timescale 1ns/1ps
module sim_crt_decoder;
    localparam int MT = 15015;
    localparam int HV = 7508;
    localparam int MV [4] = '{7, 11, 13, 15};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        fmt_i = 1'b0;
    logic [15:0] res_i = '0;
    logic        valid_o;
    logic [14:0] data_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R2";
    logic [14:0] exp_q[$];
    logic [14:0] last_exp = '0;

    always #2.5 clk = ~clk;

    crt_decoder u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .fmt_i(fmt_i),
        .res_i(res_i), .valid_o(valid_o), .data_o(data_o)
    );

    function automatic logic [15:0] enc(int x);
        logic [15:0] r;
        for (int i = 0; i < 4; i++) r[i*4 +: 4] = 4'(x % MV[i]);
        return r;
    endfunction

    function automatic logic [14:0] expect_val(int x, bit fmt);
        bit neg;
        neg = (x >= HV);
        if (fmt) return neg ? 15'(x - MT) : 15'(x);
        return {neg, 14'(neg ? MT - x : x)};
    endfunction

    task automatic check(bit ok, string req, logic [14:0] act, logic [14:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    // Scoreboard: every valid output is compared against the next expected value
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected output", data_o, '0);
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                last_exp = e;
                check(data_o == e, cur_req, data_o, e);
            end
        end
    end

    task automatic drive_vec(int x, bit fmt);
        @(negedge clk);
        res_i   = enc(x);
        fmt_i   = fmt;
        valid_i = 1'b1;
        exp_q.push_back(expect_val(x, fmt));
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            valid_i = 1'b0;
        end
    endtask

    task automatic t_reset;
        cur_req = "R8";
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(valid_o == 1'b0, "R8 valid_o after reset", 15'(valid_o), 15'd0);
        check(data_o == '0, "R8 data_o after reset", data_o, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_sweep(bit fmt);
        cur_req = fmt ? "R4 two's complement (R1 R2)" : "R3 sign-magnitude (R1 R2)";
        for (int x = 0; x < MT; x++) drive_vec(x, fmt);
        idle(8);
        check(exp_q.size() == 0, "R6 all results delivered", 15'(exp_q.size()), 15'd0);
    endtask

    task automatic t_alternate;
        cur_req = "R5 per-vector format";
        for (int k = 0; k < 3000; k++) drive_vec((k * 37 + 7400) % MT, bit'(k & 1));
        idle(8);
        check(exp_q.size() == 0, "R5 all results delivered", 15'(exp_q.size()), 15'd0);
    endtask

    task automatic t_boundary;
        cur_req = "R2 range fold";
        drive_vec(7507, 1'b1); drive_vec(7508, 1'b1);
        drive_vec(7507, 1'b0); drive_vec(7508, 1'b0);
        drive_vec(0, 1'b0);    drive_vec(15014, 1'b0);
        drive_vec(0, 1'b1);    drive_vec(15014, 1'b1);
        idle(8);
    endtask

    task automatic t_latency;
        int lat;
        lat = 0;
        cur_req = "R6 latency";
        idle(6);
        drive_vec(123, 1'b0);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            valid_i = 1'b0;
            if (valid_o && lat == 0) lat = k;
        end
        check(lat == 4, "R6 latency in edges", 15'(lat), 15'd4);
    endtask

    task automatic t_hold;
        logic [14:0] held;
        cur_req = "R7 hold";
        drive_vec(9000, 1'b1);
        drive_vec(100, 1'b0);
        idle(6);
        held = last_exp;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(!valid_o && data_o == held, "R7 data held while idle", data_o, held);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_boundary();
        t_sweep(1'b0);
        t_sweep(1'b1);
        t_alternate();
        t_hold();
        idle(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule